// File: doc/BRIEF.md
# Two-Stage Routed Event Interrupt Controller

This block collects a set of level-high event lines and turns them into a smaller set of host interrupt lines. Each event first goes through a programmable table that assigns it to a channel. A second table then assigns each channel to a host. For every event the block keeps a latched pending bit and an enable bit. Each host has an enable bit of its own, and one global enable sits over all of them. A host line is driven high when at least one pending, enabled event reaches it through both tables and all of its gates are open.

Software uses one 32-bit register port with word addresses. Writes are clocked and reads are combinational. Pending bits and enable bits can be changed in two ways. A write of an event number to an index register changes one event. A write-1 mask to a 32-event bank register changes many events at once. For each host, a priority register reports the number of the winning pending event, or a flag that says no event is pending. A service routine can read that register, handle the event, clear it by index and read again.

Top module: `evmap_intc`

## Requirements
- R1: After reset all pending bits, event enables, host enables, the global enable and every map field are 0. Every host line is low and every priority register reads 0x8000_0000.
- R2: A high level on an event input at a clock edge sets that event's pending bit. The bit stays set after the input falls. A clear of the event takes no effect while the input is still high at the clearing edge.
- R3: Writing an event number to word 0x001 sets that event's pending bit, and writing it to word 0x002 clears it. Numbers at or above the event count are ignored.
- R4: Writing an event number to word 0x003 sets its enable, and writing it to word 0x004 clears it. In bank register 0x030+b a 1 in bit i sets the enable of event 32b+i. In bank register 0x040+b a 1 in bit i clears it. Both bank registers read back the enables of their bank. Out-of-range numbers are ignored.
- R5: Word 0x010+b reads the raw pending bits of bank b. Word 0x020+b reads pending AND enable for bank b, and a write of 1 to bit i there clears the pending bit of event 32b+i.
- R6: Event-to-channel register 0x080+r holds events 4r to 4r+3. Event e uses bits [(e mod 4)*8 +: 4]. A read returns the stored fields with every other bit 0.
- R7: Channel-to-host register 0x0C0+r uses the same layout for channels 4r to 4r+3. Slots for channels beyond the channel count read 0 and ignore writes.
- R8: Host line h is high exactly when the global enable (word 0x000, bit 0) is 1, host enable h is 1, and some pending, enabled event maps through its channel to host h.
- R9: Among the candidates for one host, the event on the lowest channel number wins. On a tie in channel, the lowest event number wins.
- R10: Word 0x100+h reads 0x8000_0000 when no pending, enabled event routes to host h. Otherwise it holds the winning event number in bits 9:0 and 0 elsewhere. This holds whatever the host and global enables are.
- R11: A map write changes the routing from the next edge on, and events that are already pending follow the new routing at once.
- R12: Writing a host number to word 0x005 sets that host's enable, and writing it to word 0x006 clears it. Numbers at or above the host count are ignored. Word 0x007 reads the host enables as a bitmask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_in | input | N_EVT | Level-high event inputs |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 9 | Word address of the write |
| wr_data | input | 32 | Write data |
| rd_addr | input | 9 | Word address of the read |
| rd_data | output | 32 | Read data, combinational |
| host_irq | output | N_HOST | Host interrupt lines |

## Verification
The bench uses the default build: 64 events, 10 channels, 10 hosts and 4-bit map fields. With these values both event banks are exercised, and events in bank 1 are reached through both the index registers and the mask registers. The last channel-to-host register is only half filled, so the bench can check the slots for the missing channels 10 and 11. The first illegal numbers are 64 for events and 10 for hosts, and the bench writes exactly these edge values. Ten hosts also let the bench move one pending event to a host far from host 0 and watch it leave one priority register and appear in another.

// File: rtl/evmap_intc_pkg.sv
package evmap_intc_pkg;
   // word addresses of the register port
   localparam int ADDR_W     = 9;
   localparam int A_GLB      = 'h000;
   localparam int A_PSET     = 'h001;
   localparam int A_PCLR     = 'h002;
   localparam int A_ESET     = 'h003;
   localparam int A_ECLR     = 'h004;
   localparam int A_HSET     = 'h005;
   localparam int A_HCLR     = 'h006;
   localparam int A_HEN      = 'h007;
   localparam int A_RAW      = 'h010;
   localparam int A_ACT      = 'h020;
   localparam int A_ENS_BANK = 'h030;
   localparam int A_ENC_BANK = 'h040;
   localparam int A_EMAP     = 'h080;
   localparam int A_HMAP     = 'h0C0;
   localparam int A_PIDX     = 'h100;

   // layout constants that software depends on
   localparam int BANK_BITS  = 32;
   localparam int SLOT_BITS  = 8;
   localparam int SLOTS      = 4;
   localparam int IDX_FIELD  = 10;
   localparam logic [31:0] NONE_WORD = 32'h8000_0000;

   typedef logic [IDX_FIELD-1:0] evt_num_t;
endpackage

// File: rtl/evmap_ctrl_regs.sv
module evmap_ctrl_regs
   import evmap_intc_pkg::*;
#(
   parameter int N_EVT  = 64,
   parameter int N_HOST = 10
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_EVT-1:0]     evt_in,
   input  logic                 wr_en,
   input  logic [ADDR_W-1:0]    wr_addr,
   input  logic [31:0]          wr_data,
   output logic [N_EVT-1:0]     pend_q,
   output logic [N_EVT-1:0]     en_q,
   output logic [N_HOST-1:0]    hen_q,
   output logic                 glb_q
);
   logic [N_EVT-1:0]  pset, pclr, eset, eclr;
   logic [N_HOST-1:0] hset, hclr;

   // one-hot decode of index writes and bank masks
   always_comb begin
      pset = '0;
      pclr = '0;
      eset = '0;
      eclr = '0;
      hset = '0;
      hclr = '0;
      if (wr_en) begin
         for (int e = 0; e < N_EVT; e++) begin
            if (wr_data == 32'(e)) begin
               pset[e] = (wr_addr == ADDR_W'(A_PSET));
               pclr[e] = (wr_addr == ADDR_W'(A_PCLR));
               eset[e] = (wr_addr == ADDR_W'(A_ESET));
               eclr[e] = (wr_addr == ADDR_W'(A_ECLR));
            end
            if (wr_data[e % BANK_BITS]) begin
               if (wr_addr == ADDR_W'(A_ACT + e / BANK_BITS))      pclr[e] = 1'b1;
               if (wr_addr == ADDR_W'(A_ENS_BANK + e / BANK_BITS)) eset[e] = 1'b1;
               if (wr_addr == ADDR_W'(A_ENC_BANK + e / BANK_BITS)) eclr[e] = 1'b1;
            end
         end
         for (int h = 0; h < N_HOST; h++) begin
            if (wr_data == 32'(h)) begin
               hset[h] = (wr_addr == ADDR_W'(A_HSET));
               hclr[h] = (wr_addr == ADDR_W'(A_HCLR));
            end
         end
      end
   end

   // input level and software set both beat a clear
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= '0;
         en_q   <= '0;
         hen_q  <= '0;
         glb_q  <= 1'b0;
      end else begin
         pend_q <= (pend_q & ~pclr) | pset | evt_in;
         en_q   <= (en_q & ~eclr) | eset;
         hen_q  <= (hen_q & ~hclr) | hset;
         if (wr_en && wr_addr == ADDR_W'(A_GLB)) glb_q <= wr_data[0];
      end
   end
endmodule

// File: rtl/evmap_route_map.sv
module evmap_route_map
   import evmap_intc_pkg::*;
#(
   parameter int N_ITEM = 64,
   parameter int MAP_W  = 4,
   parameter int BASE   = A_EMAP
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [ADDR_W-1:0]             wr_addr,
   input  logic [31:0]                   wr_data,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic [31:0]                   rd_word,
   output logic [N_ITEM-1:0][MAP_W-1:0]  map_q
);
   localparam int N_REG = (N_ITEM + SLOTS - 1) / SLOTS;

   logic unused_wr;
   assign unused_wr = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         map_q <= '0;
      end else if (wr_en) begin
         for (int i = 0; i < N_ITEM; i++) begin
            if (wr_addr == ADDR_W'(BASE + i / SLOTS))
               map_q[i] <= wr_data[(i % SLOTS) * SLOT_BITS +: MAP_W];
         end
      end
   end

   always_comb begin
      rd_word = '0;
      for (int i = 0; i < N_ITEM; i++) begin
         if (rd_addr == ADDR_W'(BASE + i / SLOTS))
            rd_word[(i % SLOTS) * SLOT_BITS +: MAP_W] = map_q[i];
      end
   end

   if (N_REG > 64) begin : g_bad_depth
      $error("route map needs more than 64 registers");
   end
endmodule

// File: rtl/evmap_prio_sel.sv
module evmap_prio_sel
   import evmap_intc_pkg::*;
#(
   parameter int N_EVT  = 64,
   parameter int N_CH   = 10,
   parameter int N_HOST = 10,
   parameter int MAP_W  = 4
) (
   input  logic [N_EVT-1:0]              act,
   input  logic [N_EVT-1:0][MAP_W-1:0]   chan_of,
   input  logic [N_CH-1:0][MAP_W-1:0]    host_of,
   output logic [N_HOST-1:0]             any,
   output evt_num_t [N_HOST-1:0]         win
);
   logic [N_CH-1:0] ch_hit;
   evt_num_t [N_CH-1:0] ch_win;

   // stage 1: lowest pending event on each channel
   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      always_comb begin
         ch_hit[c] = 1'b0;
         ch_win[c] = '0;
         for (int e = N_EVT - 1; e >= 0; e--) begin
            if (act[e] && chan_of[e] == MAP_W'(c)) begin
               ch_hit[c] = 1'b1;
               ch_win[c] = IDX_FIELD'(e);
            end
         end
      end
   end

   // stage 2: lowest busy channel routed to each host
   for (genvar h = 0; h < N_HOST; h++) begin : g_host
      always_comb begin
         any[h] = 1'b0;
         win[h] = '0;
         for (int c = N_CH - 1; c >= 0; c--) begin
            if (ch_hit[c] && host_of[c] == MAP_W'(h)) begin
               any[h] = 1'b1;
               win[h] = ch_win[c];
            end
         end
      end
   end
endmodule

// File: rtl/evmap_intc.sv
module evmap_intc
   import evmap_intc_pkg::*;
#(
   parameter int N_EVT  = 64,
   parameter int N_CH   = 10,
   parameter int N_HOST = 10,
   parameter int MAP_W  = 4
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [N_EVT-1:0]     evt_in,
   input  logic                 wr_en,
   input  logic [8:0]           wr_addr,
   input  logic [31:0]          wr_data,
   input  logic [8:0]           rd_addr,
   output logic [31:0]          rd_data,
   output logic [N_HOST-1:0]    host_irq
);
   localparam int N_BANK = (N_EVT + BANK_BITS - 1) / BANK_BITS;

   if (N_EVT < 1 || N_EVT > 256) begin : g_bad_evt
      $error("N_EVT must be 1..256");
   end
   if (N_HOST < 1 || N_HOST > 2 ** MAP_W || N_HOST > 32) begin : g_bad_host
      $error("N_HOST out of range for MAP_W");
   end
   if (N_CH < 1 || N_CH > 2 ** MAP_W) begin : g_bad_ch
      $error("N_CH out of range for MAP_W");
   end
   if (MAP_W < 1 || MAP_W > SLOT_BITS) begin : g_bad_mapw
      $error("MAP_W must fit a slot");
   end
   if (N_BANK > 16) begin : g_bad_bank
      $error("bank window overflow");
   end

   logic [N_EVT-1:0]             pend_q, en_q;
   logic [N_HOST-1:0]            hen_q;
   logic                         glb_q;
   logic [N_EVT-1:0][MAP_W-1:0]  chan_of;
   logic [N_CH-1:0][MAP_W-1:0]   host_of;
   logic [31:0]                  emap_rd, hmap_rd;
   logic [N_HOST-1:0]            host_any;
   evt_num_t [N_HOST-1:0]        host_win;
   logic [N_EVT-1:0]             act;
   logic [31:0]                  misc_rd;

   evmap_ctrl_regs #(.N_EVT(N_EVT), .N_HOST(N_HOST)) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .evt_in  (evt_in),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .pend_q  (pend_q),
      .en_q    (en_q),
      .hen_q   (hen_q),
      .glb_q   (glb_q)
   );

   evmap_route_map #(.N_ITEM(N_EVT), .MAP_W(MAP_W), .BASE(A_EMAP)) u_emap (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_word (emap_rd),
      .map_q   (chan_of)
   );

   evmap_route_map #(.N_ITEM(N_CH), .MAP_W(MAP_W), .BASE(A_HMAP)) u_hmap (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_word (hmap_rd),
      .map_q   (host_of)
   );

   assign act = pend_q & en_q;

   evmap_prio_sel #(.N_EVT(N_EVT), .N_CH(N_CH), .N_HOST(N_HOST), .MAP_W(MAP_W)) u_prio (
      .act     (act),
      .chan_of (chan_of),
      .host_of (host_of),
      .any     (host_any),
      .win     (host_win)
   );

   assign host_irq = host_any & hen_q & {N_HOST{glb_q}};

   always_comb begin
      misc_rd = '0;
      if (rd_addr == ADDR_W'(A_GLB)) misc_rd[0] = glb_q;
      if (rd_addr == ADDR_W'(A_HEN)) misc_rd[N_HOST-1:0] = hen_q;
      for (int e = 0; e < N_EVT; e++) begin
         if (rd_addr == ADDR_W'(A_RAW + e / BANK_BITS))
            misc_rd[e % BANK_BITS] = pend_q[e];
         if (rd_addr == ADDR_W'(A_ACT + e / BANK_BITS))
            misc_rd[e % BANK_BITS] = act[e];
         if (rd_addr == ADDR_W'(A_ENS_BANK + e / BANK_BITS) ||
             rd_addr == ADDR_W'(A_ENC_BANK + e / BANK_BITS))
            misc_rd[e % BANK_BITS] = en_q[e];
      end
      for (int h = 0; h < N_HOST; h++) begin
         if (rd_addr == ADDR_W'(A_PIDX + h))
            misc_rd = host_any[h] ? {{(32-IDX_FIELD){1'b0}}, host_win[h]} : NONE_WORD;
      end
   end

   assign rd_data = misc_rd | emap_rd | hmap_rd;
endmodule

// File: rtl/evmap_intc_chk.sv
module evmap_intc_chk
   import evmap_intc_pkg::*;
#(
   parameter int N_EVT  = 64,
   parameter int N_HOST = 10
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_EVT-1:0]  evt_in,
   input logic              wr_en,
   input logic [8:0]        wr_addr,
   input logic [31:0]       wr_data,
   input logic [N_HOST-1:0] host_irq,
   input logic [N_HOST-1:0] host_any,
   input logic [N_EVT-1:0]  pend_q,
   input logic [N_EVT-1:0]  en_q,
   input logic              glb_q
);
   localparam int IW = (N_EVT > 1) ? $clog2(N_EVT) : 1;

   logic live_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) live_q <= 1'b0;
      else        live_q <= 1'b1;
   end

   logic in_rng;
   assign in_rng = (wr_data < 32'(N_EVT));

   // R8: no host line without the global gate
   p_glb_gate_r8: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
      !glb_q |-> host_irq == '0);

   // R8: a host line needs a routed, enabled, pending event
   p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
      (host_irq & ~host_any) == '0);

   // R2: an input level seen at an edge is pending after it
   p_level_latch_r2: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
      live_q |=> (pend_q & $past(evt_in)) == $past(evt_in));

   // R4: index enable-set lands
   p_en_set_r4: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
      (wr_en && wr_addr == 9'(A_ESET) && in_rng) |=> en_q[$past(wr_data[IW-1:0])]);

   // R3: index clear of a low input empties the bit
   p_pend_clr_r3: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
      (wr_en && wr_addr == 9'(A_PCLR) && in_rng && !evt_in[wr_data[IW-1:0]])
      |=> !pend_q[$past(wr_data[IW-1:0])]);

   // R3: out-of-range set index adds nothing beyond the inputs
   p_pend_oor_r3: assert property (@(posedge clk) disable iff (!rst_n || !live_q)
      (wr_en && wr_addr == 9'(A_PSET) && !in_rng)
      |=> pend_q == ($past(pend_q) | $past(evt_in)));
endmodule

bind evmap_intc evmap_intc_chk #(.N_EVT(N_EVT), .N_HOST(N_HOST)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .evt_in   (evt_in),
   .wr_en    (wr_en),
   .wr_addr  (wr_addr),
   .wr_data  (wr_data),
   .host_irq (host_irq),
   .host_any (host_any),
   .pend_q   (pend_q),
   .en_q     (en_q),
   .glb_q    (glb_q)
);

// File: tb/evmap_intc_bench.sv
`timescale 1ns/1ps
module evmap_intc_bench;
   localparam int NE = 64;
   localparam int NH = 10;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-1:0] evt_in = '0;
   logic          wr_en = 1'b0;
   logic [8:0]    wr_addr = '0;
   logic [31:0]   wr_data = '0;
   logic [8:0]    rd_addr = '0;
   logic [31:0]   rd_data;
   logic [NH-1:0] host_irq;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   evmap_intc u_evmap_intc (
      .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .rd_addr(rd_addr),
      .rd_data(rd_data), .host_irq(host_irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      evt_in = '0;
      wr_en = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1;
      wr_addr = 9'(a);
      wr_data = d;
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd(input int a, output logic [31:0] d);
      @(negedge clk);
      rd_addr = 9'(a);
      #1 d = rd_data;
   endtask

   task automatic rd_chk(input string req, input int a, input logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(req, d, exp);
   endtask

   task automatic t_reset();
      do_reset();
      rd_chk("R1 raw bank0", 'h010, 0);
      rd_chk("R1 raw bank1", 'h011, 0);
      rd_chk("R1 emap0", 'h080, 0);
      rd_chk("R1 hmap0", 'h0C0, 0);
      rd_chk("R1 pidx host0", 'h100, 32'h8000_0000);
      rd_chk("R1 pidx host9", 'h109, 32'h8000_0000);
      chk("R1 host_irq", 32'(host_irq), 0);
   endtask

   task automatic t_level();
      do_reset();
      @(negedge clk) evt_in[5] = 1'b1;
      @(negedge clk) evt_in[5] = 1'b0;
      rd_chk("R2 latch after pulse", 'h010, 32'h20);
      @(negedge clk) evt_in[5] = 1'b1;
      wr('h002, 5);
      rd_chk("R2 clear blocked by high level", 'h010, 32'h20);
      @(negedge clk) evt_in[5] = 1'b0;
      wr('h002, 5);
      rd_chk("R2 clear after level low", 'h010, 0);
   endtask

   task automatic t_index();
      do_reset();
      wr('h001, 40);
      rd_chk("R3 set idx 40 bank1", 'h011, 32'h100);
      wr('h001, 64);
      rd_chk("R3 oor set bank0", 'h010, 0);
      rd_chk("R3 oor set bank1", 'h011, 32'h100);
      wr('h002, 40);
      rd_chk("R3 clear idx 40", 'h011, 0);
   endtask

   task automatic t_enable();
      do_reset();
      wr('h003, 3);
      wr('h031, 32'h5);
      rd_chk("R4 idx set bank0", 'h030, 32'h8);
      rd_chk("R4 mask set bank1", 'h031, 32'h5);
      wr('h041, 32'h1);
      rd_chk("R4 mask clear via clr bank read", 'h041, 32'h4);
      wr('h004, 3);
      wr('h003, 99);
      rd_chk("R4 idx clear and oor set", 'h030, 0);
      wr('h001, 3);
      wr('h001, 4);
      wr('h003, 3);
      rd_chk("R5 active bank = pend&en", 'h020, 32'h8);
      rd_chk("R5 raw bank", 'h010, 32'h18);
      wr('h020, 32'h18);
      rd_chk("R5 write-1 clears pending", 'h010, 0);
   endtask

   task automatic t_map();
      do_reset();
      wr('h081, 32'hFFFF_FFFF);
      rd_chk("R6 emap field mask", 'h081, 32'h0F0F_0F0F);
      rd_chk("R6 neighbour untouched", 'h080, 0);
      wr('h0C2, 32'hFFFF_FFFF);
      rd_chk("R7 hmap partial register", 'h0C2, 32'h0000_0F0F);
   endtask

   task automatic t_host_en();
      do_reset();
      wr('h005, 2);
      wr('h005, 12);
      wr('h005, 10);
      rd_chk("R12 host enable set, oor ignored", 'h007, 32'h4);
      wr('h006, 2);
      rd_chk("R12 host enable clear", 'h007, 0);
   endtask

   task automatic t_route();
      do_reset();
      wr('h000, 1);
      wr('h005, 2);
      wr('h082, 32'h0003_0000);  // event 10 -> channel 3
      wr('h0C0, 32'h0200_0000);  // channel 3 -> host 2
      wr('h003, 10);
      wr('h001, 10);
      @(negedge clk);
      chk("R8 host 2 asserted", 32'(host_irq), 32'h4);
      rd_chk("R10 pidx host2", 'h102, 32'd10);
      rd_chk("R10 pidx host0 none", 'h100, 32'h8000_0000);
      wr('h000, 0);
      @(negedge clk);
      chk("R8 global gate", 32'(host_irq), 0);
      rd_chk("R10 index ignores gates", 'h102, 32'd10);
      wr('h000, 1);
      wr('h006, 2);
      @(negedge clk);
      chk("R8 host enable gate", 32'(host_irq), 0);
      wr('h005, 2);
      wr('h004, 10);
      @(negedge clk);
      chk("R8 event enable gate", 32'(host_irq), 0);
   endtask

   task automatic t_prio();
      do_reset();
      wr('h000, 1);
      wr('h005, 0);
      wr('h005, 5);
      wr('h003, 3);
      wr('h003, 7);
      wr('h001, 7);
      wr('h001, 3);
      rd_chk("R9 lower event wins in channel", 'h100, 32'd3);
      wr('h080, 32'h0100_0000);  // event 3 -> channel 1
      rd_chk("R9 lower channel wins", 'h100, 32'd7);
      wr('h0C1, 32'h0000_0005);  // channel 4 -> host 5
      wr('h081, 32'h0400_0000);  // event 7 -> channel 4
      rd_chk("R11 pending event leaves host 0", 'h100, 32'd3);
      rd_chk("R11 pending event reaches host 5", 'h105, 32'd7);
      @(negedge clk);
      chk("R11 both hosts asserted", 32'(host_irq), 32'h21);
      wr('h002, 3);
      rd_chk("R10 none after clear", 'h100, 32'h8000_0000);
   endtask

   initial begin
      #400000;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_level();
      t_index();
      t_enable();
      t_map();
      t_host_en();
      t_route();
      t_prio();
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule